// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Snooping

This block holds a handful of waiting operations in front of a single functional unit. An upstream issue stage hands it one operation at a time, in program order. Each source operand arrives either as a finished value or as the number of the station that will produce it. The bank accepts the operation into its lowest-numbered free station and reports that station's number back, so the issue stage can rename the destination register to it. When every station is occupied it raises a stall and takes nothing.

Missing operands are never read from a register file. Every station watches a shared result bus that carries a 64-bit value and a 4-bit source tag. When a pending tag matches the tag on the bus, the station copies the value in and clears the tag. A tag of zero therefore means the operand is present, and there is no separate ready flag. A station whose two tags are both zero is offered to the functional unit. The lowest-numbered such station goes first, one per cycle, and only while the unit is not busy. The unit later puts its result on the same bus under the station's tag, and that broadcast frees the station.

Top module: `resv_bank`

## Requirements
- R1: After reset every station is free, issueStall is 0, issueTag is 1 and dispValid is 0.
- R2: Stations are numbered 1 to NUM_ST, and tag value 0 means "no producer". While a station is free, issueTag shows the lowest-numbered free station. An operation presented with issueValid is stored in that station on the next clock edge.
- R3: When all stations are busy, issueStall is 1 and issueTag is 0. An operation presented during a stall is dropped and is never dispatched.
- R4: A station is offered to the functional unit only when both of its producer tags are zero. The offer shows the station's opcode, both operand values and the station number (dispTag).
- R5: When bcValid is high, every held nonzero tag equal to bcTag takes bcData into its operand value and clears to zero. The station becomes eligible for dispatch in the cycle after the capture edge.
- R6: Each operand snoops on its own, so the two operands of one station may be filled by two different broadcasts. A broadcast whose tag matches neither held tag changes nothing.
- R7: A broadcast whose bcTag equals a busy station's number frees that station. That number becomes available to issue from the next cycle, even while lower and higher stations stay busy.
- R8: When several stations are ready, the lowest-numbered one is offered. No offer is made while fuBusy is 1. A station accepted by the unit (dispValid with fuBusy 0 at a clock edge) is not offered again.
- R9: If an issuing operand names a producer tag that is being broadcast in the same cycle, the station stores the broadcast value with a zero tag.
- R10: An operation issued with both tags zero is offered in the cycle right after the issue edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is presented for issue |
| issueOp | input | OP_W | Opcode of the issuing operation |
| issueValJ | input | DATA_W | First operand value, used when issueTagJ is 0 |
| issueTagJ | input | 4 | Producer of the first operand, 0 if the value is present |
| issueValK | input | DATA_W | Second operand value, used when issueTagK is 0 |
| issueTagK | input | 4 | Producer of the second operand, 0 if the value is present |
| issueStall | output | 1 | No station is free; the issue is not taken |
| issueTag | output | 4 | Number of the station that will take the issue, 0 when stalled |
| bcValid | input | 1 | The result bus carries a result this cycle |
| bcTag | input | 4 | Number of the station whose result is on the bus |
| bcData | input | DATA_W | Result value on the bus |
| fuBusy | input | 1 | The functional unit cannot take an operation this cycle |
| dispValid | output | 1 | An operation is offered to the functional unit |
| dispTag | output | 4 | Station number of the offered operation |
| dispOp | output | OP_W | Opcode of the offered operation |
| dispValJ | output | DATA_W | First operand of the offered operation |
| dispValK | output | DATA_W | Second operand of the offered operation |

## Verification
The hardest case to reach from the ports is a station that has to wait while a higher-numbered one goes ahead of it. Readiness also has to land on the exact edge where a broadcast is captured, not one cycle early. The bench issues an operation whose operand names a station that stays free, so only a hand-driven broadcast can fill it. Two ready operations are queued behind it. The bench then steps the unit's busy input cycle by cycle, so that the ready stations leave in order and the waiting station is released one cycle after its broadcast. Issue-time bypass is reached by driving the broadcast and a matching issue in the same cycle.

// File: rtl/resv_pkg.sv
`timescale 1ns/1ps
package resv_pkg;
  // The result bus tag is fixed at four bits; station numbers live in 1..15.
  localparam int TAG_W = 4;
  typedef logic [TAG_W-1:0] tag_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic issueFire;   // write the issuing operation this edge
    tag_t issueIdx;    // target station number
    logic dispFire;    // functional unit takes the offered station
    tag_t dispIdx;     // offered station number (0 = none ready)
  } ctrlStrobes_t;
endpackage

// File: rtl/resv_slot.sv
`timescale 1ns/1ps
// One station's operand storage with broadcast snoop on both operands.
module resv_slot import resv_pkg::*; #(
  parameter int OP_W   = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inValJ,
  input  tag_t              inTagJ,
  input  logic [DATA_W-1:0] inValK,
  input  tag_t              inTagK,
  input  logic              bcValid,
  input  tag_t              bcTag,
  input  logic [DATA_W-1:0] bcData,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] valJ,
  output logic [DATA_W-1:0] valK,
  output logic              opsReady
);
  logic [DATA_W-1:0] inVal [2];
  tag_t              inTag [2];
  logic [DATA_W-1:0] heldVal [2];
  tag_t              heldTag [2];

  assign inVal[0] = inValJ;
  assign inVal[1] = inValK;
  assign inTag[0] = inTagJ;
  assign inTag[1] = inTagK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) op <= '0;
    else if (load) op <= inOp;
  end

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [DATA_W-1:0] valQ;
    tag_t              tagQ;
    logic              hitIssue;
    logic              hitHeld;

    // same-cycle producer on the bus: take the value, never store the tag
    assign hitIssue = bcValid && (inTag[k] != '0) && (bcTag == inTag[k]);
    assign hitHeld  = bcValid && (tagQ != '0) && (bcTag == tagQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valQ <= '0;
        tagQ <= '0;
      end else if (load) begin
        valQ <= hitIssue ? bcData : inVal[k];
        tagQ <= hitIssue ? tag_t'(0) : inTag[k];
      end else if (hitHeld) begin
        valQ <= bcData;
        tagQ <= '0;
      end
    end

    assign heldVal[k] = valQ;
    assign heldTag[k] = tagQ;
  end

  assign valJ     = heldVal[0];
  assign valK     = heldVal[1];
  assign opsReady = (heldTag[0] == '0) && (heldTag[1] == '0);
endmodule

// File: rtl/resv_data.sv
`timescale 1ns/1ps
// Datapath: the array of station slots and the dispatch multiplexer.
module resv_data import resv_pkg::*; #(
  parameter int NUM_ST = 4,
  parameter int OP_W   = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [DATA_W-1:0] issueValJ,
  input  tag_t              issueTagJ,
  input  logic [DATA_W-1:0] issueValK,
  input  tag_t              issueTagK,
  input  logic              bcValid,
  input  tag_t              bcTag,
  input  logic [DATA_W-1:0] bcData,
  output logic [NUM_ST-1:0] opsReady,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispValJ,
  output logic [DATA_W-1:0] dispValK
);
  logic [OP_W-1:0]   slotOp  [NUM_ST];
  logic [DATA_W-1:0] slotJ   [NUM_ST];
  logic [DATA_W-1:0] slotK   [NUM_ST];

  for (genvar i = 0; i < NUM_ST; i++) begin : g_slot
    logic loadHere;
    assign loadHere = strobes.issueFire && (strobes.issueIdx == tag_t'(i + 1));

    resv_slot #(.OP_W(OP_W), .DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .load     (loadHere),
      .inOp     (issueOp),
      .inValJ   (issueValJ),
      .inTagJ   (issueTagJ),
      .inValK   (issueValK),
      .inTagK   (issueTagK),
      .bcValid  (bcValid),
      .bcTag    (bcTag),
      .bcData   (bcData),
      .op       (slotOp[i]),
      .valJ     (slotJ[i]),
      .valK     (slotK[i]),
      .opsReady (opsReady[i])
    );
  end

  always_comb begin
    dispOp   = '0;
    dispValJ = '0;
    dispValK = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (strobes.dispIdx == tag_t'(i + 1)) begin
        dispOp   = slotOp[i];
        dispValJ = slotJ[i];
        dispValK = slotK[i];
      end
    end
    if (!strobes.dispFire) begin
      dispOp   = '0;
      dispValJ = '0;
      dispValK = '0;
    end
  end
endmodule

// File: rtl/resv_ctrl.sv
`timescale 1ns/1ps
// Control: busy and executing flags per station, free and ready pickers.
module resv_ctrl import resv_pkg::*; #(
  parameter int NUM_ST = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              fuBusy,
  input  logic              bcValid,
  input  tag_t              bcTag,
  input  logic [NUM_ST-1:0] opsReady,
  output ctrlStrobes_t      strobes,
  output logic              issueStall,
  output tag_t              issueTag,
  output logic [NUM_ST-1:0] busyVec
);
  logic [NUM_ST-1:0] execVec;
  logic [NUM_ST-1:0] readyVec;
  tag_t              freeIdx;
  tag_t              readyIdx;

  assign readyVec = busyVec & ~execVec & opsReady;

  // lowest number wins: scan from the top so the last hit is the smallest
  always_comb begin
    freeIdx  = '0;
    readyIdx = '0;
    for (int i = NUM_ST - 1; i >= 0; i--) begin
      if (!busyVec[i])  freeIdx  = tag_t'(i + 1);
      if (readyVec[i])  readyIdx = tag_t'(i + 1);
    end
  end

  assign issueStall = (freeIdx == '0);
  assign issueTag   = freeIdx;

  always_comb begin
    strobes.issueFire = issueValid && !issueStall;
    strobes.issueIdx  = freeIdx;
    strobes.dispFire  = (readyIdx != '0) && !fuBusy;
    strobes.dispIdx   = readyIdx;
  end

  for (genvar i = 0; i < NUM_ST; i++) begin : g_flag
    logic busyQ;
    logic execQ;
    logic issueHit;
    logic freeHit;
    logic dispHit;

    assign issueHit = strobes.issueFire && (strobes.issueIdx == tag_t'(i + 1));
    assign freeHit  = bcValid && (bcTag == tag_t'(i + 1));
    assign dispHit  = strobes.dispFire && (strobes.dispIdx == tag_t'(i + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyQ <= 1'b0;
        execQ <= 1'b0;
      end else if (issueHit) begin
        busyQ <= 1'b1;
        execQ <= 1'b0;
      end else if (freeHit) begin
        busyQ <= 1'b0;
        execQ <= 1'b0;
      end else if (dispHit) begin
        execQ <= 1'b1;
      end
    end

    assign busyVec[i] = busyQ;
    assign execVec[i] = execQ;
  end
endmodule

// File: rtl/resv_bank.sv
`timescale 1ns/1ps
// Reservation station bank in front of one functional unit.
module resv_bank import resv_pkg::*; #(
  parameter int NUM_ST = 4,
  parameter int OP_W   = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [DATA_W-1:0] issueValJ,
  input  logic [3:0]        issueTagJ,
  input  logic [DATA_W-1:0] issueValK,
  input  logic [3:0]        issueTagK,
  output logic              issueStall,
  output logic [3:0]        issueTag,
  input  logic              bcValid,
  input  logic [3:0]        bcTag,
  input  logic [DATA_W-1:0] bcData,
  input  logic              fuBusy,
  output logic              dispValid,
  output logic [3:0]        dispTag,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispValJ,
  output logic [DATA_W-1:0] dispValK
);
  ctrlStrobes_t      strobes;
  logic [NUM_ST-1:0] opsReady;
  logic [NUM_ST-1:0] busyVec;

  resv_ctrl #(.NUM_ST(NUM_ST)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .fuBusy     (fuBusy),
    .bcValid    (bcValid),
    .bcTag      (bcTag),
    .opsReady   (opsReady),
    .strobes    (strobes),
    .issueStall (issueStall),
    .issueTag   (issueTag),
    .busyVec    (busyVec)
  );

  resv_data #(.NUM_ST(NUM_ST), .OP_W(OP_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .issueOp   (issueOp),
    .issueValJ (issueValJ),
    .issueTagJ (issueTagJ),
    .issueValK (issueValK),
    .issueTagK (issueTagK),
    .bcValid   (bcValid),
    .bcTag     (bcTag),
    .bcData    (bcData),
    .opsReady  (opsReady),
    .dispOp    (dispOp),
    .dispValJ  (dispValJ),
    .dispValK  (dispValK)
  );

  assign dispValid = strobes.dispFire;
  assign dispTag   = strobes.dispFire ? strobes.dispIdx : 4'd0;
endmodule

// File: rtl/resv_bank_chk.sv
`timescale 1ns/1ps
module resv_bank_chk #(
  parameter int NUM_ST = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              issueStall,
  input logic [3:0]        issueTag,
  input logic              bcValid,
  input logic [3:0]        bcTag,
  input logic              fuBusy,
  input logic              dispValid,
  input logic [3:0]        dispTag,
  input logic [NUM_ST-1:0] busyVec
);
  p_tag_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    !issueStall |-> (issueTag != 4'd0) && (issueTag <= 4'(NUM_ST)));

  p_fu_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    fuBusy |-> !dispValid);

  p_disp_named_r4: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (dispTag != 4'd0));

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    p_issue_marks_r2: assert property (@(posedge clk) disable iff (!rstN)
      (issueValid && !issueStall && issueTag == 4'(i + 1)) |=> busyVec[i]);

    p_bc_frees_r7: assert property (@(posedge clk) disable iff (!rstN)
      (bcValid && bcTag == 4'(i + 1) && busyVec[i]) |=> !busyVec[i]);

    p_disp_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
      (dispValid && dispTag == 4'(i + 1)) |-> busyVec[i]);

    p_once_r8: assert property (@(posedge clk) disable iff (!rstN)
      (dispValid && !fuBusy && dispTag == 4'(i + 1)) |=>
        !(dispValid && dispTag == 4'(i + 1)));
  end
endmodule

bind resv_bank resv_bank_chk #(.NUM_ST(NUM_ST)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueStall (issueStall),
  .issueTag   (issueTag),
  .bcValid    (bcValid),
  .bcTag      (bcTag),
  .fuBusy     (fuBusy),
  .dispValid  (dispValid),
  .dispTag    (dispTag),
  .busyVec    (busyVec)
);

// File: tb/resv_bank_bench.sv
`timescale 1ns/1ps
module resv_bank_bench;
  localparam int OP_W = 6;
  localparam int DW   = 64;

  logic          clk = 1'b0;
  logic          rstN;
  logic          issueValid;
  logic [OP_W-1:0] issueOp;
  logic [DW-1:0] issueValJ, issueValK;
  logic [3:0]    issueTagJ, issueTagK;
  logic          issueStall;
  logic [3:0]    issueTag;
  logic          bcValid;
  logic [3:0]    bcTag;
  logic [DW-1:0] bcData;
  logic          fuBusy;
  logic          dispValid;
  logic [3:0]    dispTag;
  logic [OP_W-1:0] dispOp;
  logic [DW-1:0] dispValJ, dispValK;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  resv_bank #(.NUM_ST(4), .OP_W(OP_W), .DATA_W(DW)) u_resv_bank (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueOp(issueOp),
    .issueValJ(issueValJ), .issueTagJ(issueTagJ),
    .issueValK(issueValK), .issueTagK(issueTagK),
    .issueStall(issueStall), .issueTag(issueTag),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData),
    .fuBusy(fuBusy),
    .dispValid(dispValid), .dispTag(dispTag), .dispOp(dispOp),
    .dispValJ(dispValJ), .dispValK(dispValK)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    issueValid = 1'b0; issueOp = '0;
    issueValJ = '0; issueValK = '0; issueTagJ = '0; issueTagK = '0;
    bcValid = 1'b0; bcTag = '0; bcData = '0;
  endtask

  task automatic drive_issue(input logic [OP_W-1:0] op,
                             input logic [DW-1:0] vj, input logic [3:0] tj,
                             input logic [DW-1:0] vk, input logic [3:0] tk);
    issueValid = 1'b1; issueOp = op;
    issueValJ = vj; issueTagJ = tj; issueValK = vk; issueTagK = tk;
  endtask

  task automatic drive_bc(input logic [3:0] t, input logic [DW-1:0] d);
    bcValid = 1'b1; bcTag = t; bcData = d;
  endtask

  task automatic free_one(input logic [3:0] t);
    idle(); drive_bc(t, 64'h0); tick(); idle();
  endtask

  task automatic t_reset();
    fuBusy = 1'b0;
    #1;
    check("R1", "issueStall", 64'(issueStall), 64'd0);
    check("R1", "issueTag", 64'(issueTag), 64'd1);
    check("R1", "dispValid", 64'(dispValid), 64'd0);
    fuBusy = 1'b1;
  endtask

  task automatic t_basic();
    drive_issue(6'd3, 64'd10, 4'd0, 64'd20, 4'd0);
    #1 check("R2", "issueTag", 64'(issueTag), 64'd1);
    tick(); idle(); fuBusy = 1'b0;
    #1;
    check("R10", "dispValid", 64'(dispValid), 64'd1);
    check("R4", "dispTag", 64'(dispTag), 64'd1);
    check("R4", "dispOp", 64'(dispOp), 64'd3);
    check("R4", "dispValJ", dispValJ, 64'd10);
    check("R4", "dispValK", dispValK, 64'd20);
    tick();
    #1 check("R8", "no re-offer", 64'(dispValid), 64'd0);
    free_one(4'd1);
    #1 check("R7", "issueTag after free", 64'(issueTag), 64'd1);
    fuBusy = 1'b1;
  endtask

  task automatic t_fill();
    for (int k = 0; k < 4; k++) begin
      drive_issue(6'(k + 1), 64'(k + 100), 4'd0, 64'(k + 200), 4'd0);
      #1 check("R2", "issueTag fill", 64'(issueTag), 64'(k + 1));
      tick();
    end
    idle();
    #1;
    check("R3", "issueStall", 64'(issueStall), 64'd1);
    check("R3", "issueTag stalled", 64'(issueTag), 64'd0);
    drive_issue(6'd9, 64'd9, 4'd0, 64'd9, 4'd0);
    tick(); idle(); fuBusy = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R8", "dispTag order", 64'(dispTag), 64'(k + 1));
      check("R8", "dispOp order", 64'(dispOp), 64'(k + 1));
      tick();
    end
    #1 check("R3", "dropped issue not offered", 64'(dispValid), 64'd0);
    fuBusy = 1'b1;
    for (int k = 0; k < 4; k++) free_one(4'(k + 1));
    #1 check("R7", "all free", 64'(issueTag), 64'd1);
  endtask

  task automatic t_snoop();
    drive_issue(6'd5, 64'hDEAD, 4'd3, 64'hBEEF, 4'd4);
    tick(); idle(); fuBusy = 1'b0;
    #1 check("R4", "waiting not offered", 64'(dispValid), 64'd0);
    drive_bc(4'd2, 64'hBAD);
    tick(); idle();
    #1 check("R6", "non-matching tag", 64'(dispValid), 64'd0);
    drive_bc(4'd3, 64'd111);
    tick(); idle();
    drive_bc(4'd4, 64'd222);
    #1 check("R6", "K still missing", 64'(dispValid), 64'd0);
    tick(); idle();
    #1;
    check("R5", "ready after capture", 64'(dispValid), 64'd1);
    check("R5", "captured J", dispValJ, 64'd111);
    check("R6", "captured K", dispValK, 64'd222);
    tick();
    fuBusy = 1'b1;
    free_one(4'd1);
  endtask

  task automatic t_bypass();
    drive_issue(6'd7, 64'h0, 4'd3, 64'd5, 4'd0);
    drive_bc(4'd3, 64'd777);
    #1 check("R9", "issueTag", 64'(issueTag), 64'd1);
    tick(); idle(); fuBusy = 1'b0;
    #1;
    check("R9", "bypass ready", 64'(dispValid), 64'd1);
    check("R9", "bypass J", dispValJ, 64'd777);
    check("R9", "bypass K", dispValK, 64'd5);
    tick();
    fuBusy = 1'b1;
    free_one(4'd1);
  endtask

  task automatic t_priority();
    drive_issue(6'd1, 64'h0, 4'd4, 64'd1, 4'd0); tick();
    drive_issue(6'd2, 64'd2, 4'd0, 64'd2, 4'd0); tick();
    drive_issue(6'd3, 64'd3, 4'd0, 64'd3, 4'd0); tick();
    idle(); fuBusy = 1'b0;
    #1 check("R8", "lowest ready first", 64'(dispTag), 64'd2);
    tick(); fuBusy = 1'b1;
    #1 check("R8", "held by fuBusy", 64'(dispValid), 64'd0);
    tick(); fuBusy = 1'b0;
    #1 check("R8", "next ready", 64'(dispTag), 64'd3);
    tick();
    #1 check("R8", "station 1 still waiting", 64'(dispValid), 64'd0);
    drive_bc(4'd4, 64'h44);
    tick(); idle();
    #1;
    check("R5", "late station offered", 64'(dispTag), 64'd1);
    check("R5", "late J", dispValJ, 64'h44);
    tick(); fuBusy = 1'b1;
    free_one(4'd2);
    #1;
    check("R7", "middle station reused", 64'(issueTag), 64'd2);
    check("R7", "no stall", 64'(issueStall), 64'd0);
    free_one(4'd1);
    free_one(4'd3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 50000);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rstN = 1'b0; fuBusy = 1'b1; idle();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_fill();
    t_snoop();
    t_bypass();
    t_priority();
    repeat (2) tick();
    finish_run();
  end
endmodule